// File: doc/BRIEF.md
# Time Pulse Conditioner and Instrument Timebase

This block takes the raw time-pulse line from the spacecraft, cleans it, and decides from the width of each pulse whether it is a spin pulse or a one-pulse-per-second (1PPS) mark. A free-running counter on the 16.78 MHz system clock forms the instrument timebase. The counter value is captured into a separate register for each kind of accepted pulse. The same counter drives a periodic processor interrupt tick, a DMA buffer-swap tick and a watchdog that raises a reset request when software stops kicking it.

The raw line first passes through a synchronizer. A glitch filter then passes a level change only after the synchronized input has differed from the filtered level for `FILT_LEN` consecutive clocks. The default is 4 clocks, about 238 ns, so pulses of 200 ns or less are rejected. A width-classifier state machine has three states:

- `CL_IDLE`: waiting for the line to go high. The filtered line going high moves it to `CL_HIGH` with a width count of 1.
- `CL_HIGH`: measuring the pulse. Each further high cycle adds one to the width. When the line falls, the machine returns to `CL_IDLE` and classifies the width. If a high cycle arrives while the width already equals `PPS_MAX`, it moves to `CL_TOOLONG` and raises the error.
- `CL_TOOLONG`: the pulse is too long. The machine stays here until the line falls, then returns to `CL_IDLE`.

Defaults: spin covers 17 to 252 clocks (about 1 to 15 µs). 1PPS covers 253 to 16780 clocks (about 15 µs to 1 ms). Any other width that passes the filter sets a sticky error.

Top module: `pulse_timekeeper`

## Requirements
- R1: After reset, the timebase, both timestamps, both strobes, both ticks, the error flag and the watchdog request are all zero.
- R2: `tbase_o` increases by one on every clock and wraps modulo 2^CNT_W.
- R3: A raw high pulse shorter than `FILT_LEN` clocks produces no strobe and does not set the error flag. A pulse of `FILT_LEN` clocks or more is measured with its raw width in clocks.
- R4: A width W with SPIN_MIN ≤ W ≤ SPIN_MAX produces exactly one single-cycle `spin_stb_o` and no `pps_stb_o`.
- R5: A width W with SPIN_MAX < W ≤ PPS_MAX produces exactly one single-cycle `pps_stb_o` and no `spin_stb_o`.
- R6: A width that passes the filter but lies outside both ranges produces no strobe and sets `width_err_o`. The flag stays set until `err_clr` is high for a clock, and a new error in that same clock wins over the clear.
- R7: In the clock after a strobe, the matching timestamp output holds the value `tbase_o` had during the strobe cycle. The other timestamp is unchanged.
- R8: `irq_tick_o` is high for one cycle exactly when the low `IRQ_BIT` bits of the previous cycle's `tbase_o` were all ones.
- R9: `swap_tick_o` follows the same rule as R8, using the low `SWAP_BIT` bits.
- R10: Once `wd_kick` is sampled high, `wd_reset_o` stays low for the next 2^WD_W − 1 clocks and rises for a single cycle at the 2^WD_W-th, unless another kick comes first.
- R11: `spin_stb_o` and `pps_stb_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tpulse_raw | input | 1 | Unsynchronized spacecraft time-pulse line |
| wd_kick | input | 1 | Software watchdog service strobe |
| err_clr | input | 1 | Clears the sticky width error |
| tbase_o | output | CNT_W | Free-running timebase |
| spin_stamp_o | output | CNT_W | Timebase captured at the last spin pulse |
| pps_stamp_o | output | CNT_W | Timebase captured at the last 1PPS |
| spin_stb_o | output | 1 | One-cycle spin pulse strobe |
| pps_stb_o | output | 1 | One-cycle 1PPS strobe |
| width_err_o | output | 1 | Sticky invalid-width flag |
| irq_tick_o | output | 1 | Periodic interrupt tick |
| swap_tick_o | output | 1 | DMA buffer-swap tick |
| wd_reset_o | output | 1 | One-cycle watchdog reset request |

## Verification
The embedded properties assume two things about the raw line: it is held for whole clock cycles, and its low gaps are longer than `FILT_LEN` plus the synchronizer depth, so that every filtered pulse is seen as a separate rising and falling edge. The bench drives the line from negative-edge-timed tasks. It leaves a 60-cycle low gap after every pulse. It also sweeps every width from 1 up to a few clocks past `PPS_MAX` in a small configuration, so each range edge, and each of the two edges of the error region, is hit exactly.

// File: rtl/tk_pkg.sv
package tk_pkg;
    typedef enum logic [1:0] {
        CL_IDLE    = 2'd0,
        CL_HIGH    = 2'd1,
        CL_TOOLONG = 2'd2
    } cls_state_t;
endpackage

// File: rtl/tk_glitch_filter.sv
module tk_glitch_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);
    localparam int CW = $clog2(FILT_LEN) + 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          run_q;
    logic                   sync_s;

    assign sync_s = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            run_q  <= '0;
            filt_o <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
            if (sync_s == filt_o) begin
                run_q <= '0;
            end else if (run_q == CW'(FILT_LEN - 1)) begin
                run_q  <= '0;
                filt_o <= sync_s;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    AST_FILT_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_o != $past(filt_o)) |-> ($past(sync_s) != $past(filt_o))); // R3
endmodule

// File: rtl/tk_width_classifier.sv
module tk_width_classifier
    import tk_pkg::*;
#(
    parameter int SPIN_MIN = 17,
    parameter int SPIN_MAX = 252,
    parameter int PPS_MAX  = 16780
) (
    input  logic clk,
    input  logic rst_n,
    input  logic filt_i,
    input  logic err_clr,
    output logic spin_stb,
    output logic pps_stb,
    output logic width_err
);
    localparam int WW = $clog2(PPS_MAX + 2);

    cls_state_t    st_q, st_d;
    logic [WW-1:0] w_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CL_IDLE:    if (filt_i) st_d = CL_HIGH;
            CL_HIGH:    if (!filt_i) st_d = CL_IDLE;
                        else if (w_q == WW'(PPS_MAX)) st_d = CL_TOOLONG;
            CL_TOOLONG: if (!filt_i) st_d = CL_IDLE;
            default:    st_d = CL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CL_IDLE;
        else        st_q <= st_d;
    end

    logic fall_in_high, is_spin, is_pps, bad_len, too_long;
    assign fall_in_high = (st_q == CL_HIGH) && !filt_i;
    assign is_spin  = (w_q >= WW'(SPIN_MIN)) && (w_q <= WW'(SPIN_MAX));
    assign is_pps   = (w_q >  WW'(SPIN_MAX)) && (w_q <= WW'(PPS_MAX));
    assign bad_len  = fall_in_high && !is_spin && !is_pps;
    assign too_long = (st_q == CL_HIGH) && (st_d == CL_TOOLONG);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q       <= '0;
            spin_stb  <= 1'b0;
            pps_stb   <= 1'b0;
            width_err <= 1'b0;
        end else begin
            if (st_q == CL_IDLE)        w_q <= WW'(1);
            else if (st_q == CL_HIGH)   w_q <= w_q + 1'b1;
            spin_stb <= fall_in_high && is_spin;
            pps_stb  <= fall_in_high && is_pps;
            if (bad_len || too_long)    width_err <= 1'b1;
            else if (err_clr)           width_err <= 1'b0;
        end
    end

    AST_STB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(spin_stb && pps_stb)); // R11
    AST_SPIN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        spin_stb |=> !spin_stb); // R4
    AST_PPS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        pps_stb |=> !pps_stb); // R5
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (width_err && !err_clr) |=> width_err); // R6
endmodule

// File: rtl/tk_rollover_tick.sv
module tk_rollover_tick #(
    parameter int CNT_W    = 24,
    parameter int TICK_BIT = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tbase_i,
    output logic             tick_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) tick_o <= 1'b0;
        else        tick_o <= &tbase_i[TICK_BIT-1:0];
    end

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o); // R8
endmodule

// File: rtl/tk_watchdog.sv
module tk_watchdog #(
    parameter int WD_W = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic wd_reset
);
    logic [WD_W-1:0] idle_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_q   <= '0;
            wd_reset <= 1'b0;
        end else begin
            idle_q   <= kick ? '0 : idle_q + 1'b1;
            wd_reset <= !kick && (&idle_q);
        end
    end

    AST_WD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wd_reset |=> !wd_reset); // R10
    AST_WD_KICK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !wd_reset); // R10
endmodule

// File: rtl/pulse_timekeeper.sv
module pulse_timekeeper #(
    parameter int CNT_W       = 24,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4,
    parameter int SPIN_MIN    = 17,
    parameter int SPIN_MAX    = 252,
    parameter int PPS_MAX     = 16780,
    parameter int IRQ_BIT     = 14,
    parameter int SWAP_BIT    = 14,
    parameter int WD_W        = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tpulse_raw,
    input  logic             wd_kick,
    input  logic             err_clr,
    output logic [CNT_W-1:0] tbase_o,
    output logic [CNT_W-1:0] spin_stamp_o,
    output logic [CNT_W-1:0] pps_stamp_o,
    output logic             spin_stb_o,
    output logic             pps_stb_o,
    output logic             width_err_o,
    output logic             irq_tick_o,
    output logic             swap_tick_o,
    output logic             wd_reset_o
);
    logic filt;

    tk_glitch_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
        .clk(clk), .rst_n(rst_n), .raw_i(tpulse_raw), .filt_o(filt));

    tk_width_classifier #(.SPIN_MIN(SPIN_MIN), .SPIN_MAX(SPIN_MAX), .PPS_MAX(PPS_MAX)) u_cls (
        .clk(clk), .rst_n(rst_n), .filt_i(filt), .err_clr(err_clr),
        .spin_stb(spin_stb_o), .pps_stb(pps_stb_o), .width_err(width_err_o));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbase_o      <= '0;
            spin_stamp_o <= '0;
            pps_stamp_o  <= '0;
        end else begin
            tbase_o <= tbase_o + 1'b1;
            if (spin_stb_o) spin_stamp_o <= tbase_o;
            if (pps_stb_o)  pps_stamp_o  <= tbase_o;
        end
    end

    localparam int TICK_BITS [2] = '{IRQ_BIT, SWAP_BIT};
    logic [1:0] ticks;

    for (genvar g = 0; g < 2; g++) begin : g_tick
        tk_rollover_tick #(.CNT_W(CNT_W), .TICK_BIT(TICK_BITS[g])) u_tick (
            .clk(clk), .rst_n(rst_n), .tbase_i(tbase_o), .tick_o(ticks[g]));
    end
    assign irq_tick_o  = ticks[0];
    assign swap_tick_o = ticks[1];

    tk_watchdog #(.WD_W(WD_W)) u_wd (
        .clk(clk), .rst_n(rst_n), .kick(wd_kick), .wd_reset(wd_reset_o));

    AST_SPIN_STAMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(spin_stb_o) |-> $stable(spin_stamp_o)); // R7
    AST_PPS_STAMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pps_stb_o) |-> $stable(pps_stamp_o)); // R7
endmodule

// File: tb/tb_pulse_timekeeper.sv
module tb_pulse_timekeeper;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 8, FILT_LEN = 4, SPIN_MIN = 6, SPIN_MAX = 12, PPS_MAX = 30;
    localparam int IRQ_BIT = 3, SWAP_BIT = 5, WD_W = 6;

    logic clk = 1'b0, rst_n = 1'b0, tpulse_raw = 1'b0, wd_kick = 1'b0, err_clr = 1'b0;
    logic [CNT_W-1:0] tbase_o, spin_stamp_o, pps_stamp_o;
    logic spin_stb_o, pps_stb_o, width_err_o, irq_tick_o, swap_tick_o, wd_reset_o;

    int checks = 0, failures = 0;

    pulse_timekeeper #(.CNT_W(CNT_W), .SYNC_STAGES(2), .FILT_LEN(FILT_LEN),
        .SPIN_MIN(SPIN_MIN), .SPIN_MAX(SPIN_MAX), .PPS_MAX(PPS_MAX),
        .IRQ_BIT(IRQ_BIT), .SWAP_BIT(SWAP_BIT), .WD_W(WD_W)) dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Continuous monitor of the counter and ticks (R2, R8, R9)
    bit mon_en = 0, have_prev = 0;
    logic [CNT_W-1:0] prev_t;
    always @(negedge clk) begin
        if (mon_en) begin
            if (have_prev) begin
                chk(tbase_o == CNT_W'(prev_t + 1), "R2", tbase_o, CNT_W'(prev_t + 1));
                chk(irq_tick_o == (prev_t[IRQ_BIT-1:0] == '1), "R8", irq_tick_o,
                    prev_t[IRQ_BIT-1:0] == '1);
                chk(swap_tick_o == (prev_t[SWAP_BIT-1:0] == '1), "R9", swap_tick_o,
                    prev_t[SWAP_BIT-1:0] == '1);
            end
            prev_t = tbase_o;
            have_prev = 1;
        end
    end

    // Drive one pulse of width w and observe strobes, stamps and error
    task automatic run_pulse(input int w);
        int n_spin = 0, n_pps = 0, both = 0;
        logic [CNT_W-1:0] exp_spin, exp_pps, cap;
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
        chk(width_err_o == 1'b0, "R6", width_err_o, 0);
        exp_spin = spin_stamp_o; exp_pps = pps_stamp_o;
        tpulse_raw = 1'b1;
        repeat (w) @(negedge clk);
        tpulse_raw = 1'b0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (spin_stb_o && pps_stb_o) both++;
            if (spin_stb_o || pps_stb_o) begin
                cap = tbase_o;
                if (spin_stb_o) begin n_spin++; exp_spin = cap; end
                if (pps_stb_o)  begin n_pps++;  exp_pps  = cap; end
                @(negedge clk); i++;
                chk(spin_stamp_o == exp_spin, "R7", spin_stamp_o, exp_spin);
                chk(pps_stamp_o == exp_pps, "R7", pps_stamp_o, exp_pps);
            end
        end
        chk(both == 0, "R11", both, 0);
        if (w < FILT_LEN) begin
            chk(n_spin + n_pps == 0, "R3", n_spin + n_pps, 0);
            chk(width_err_o == 1'b0, "R3", width_err_o, 0);
        end else if (w >= SPIN_MIN && w <= SPIN_MAX) begin
            chk(n_spin == 1 && n_pps == 0, "R4", n_spin * 10 + n_pps, 10);
            chk(width_err_o == 1'b0, "R4", width_err_o, 0);
        end else if (w > SPIN_MAX && w <= PPS_MAX) begin
            chk(n_pps == 1 && n_spin == 0, "R5", n_spin * 10 + n_pps, 1);
            chk(width_err_o == 1'b0, "R5", width_err_o, 0);
        end else begin
            chk(n_spin + n_pps == 0, "R6", n_spin + n_pps, 0);
            chk(width_err_o == 1'b1, "R6", width_err_o, 1);
        end
        chk(spin_stamp_o == exp_spin && pps_stamp_o == exp_pps, "R7", spin_stamp_o, exp_spin);
    endtask

    initial begin : main
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(tbase_o == 0 && spin_stamp_o == 0 && pps_stamp_o == 0, "R1", tbase_o, 0);
        chk({spin_stb_o, pps_stb_o, width_err_o, irq_tick_o, swap_tick_o, wd_reset_o} == 0,
            "R1", {spin_stb_o, pps_stb_o, width_err_o, irq_tick_o, swap_tick_o, wd_reset_o}, 0);
        rst_n = 1'b1;
        mon_en = 1;
        // R3..R7, R11: exhaustive width sweep
        for (int w = 1; w <= PPS_MAX + 4; w++) run_pulse(w);
        // R6: error persists without clear, then clears
        tpulse_raw = 1'b1; repeat (FILT_LEN) @(negedge clk); tpulse_raw = 1'b0;
        repeat (40) @(negedge clk);
        chk(width_err_o == 1'b1, "R6", width_err_o, 1);
        run_pulse(SPIN_MIN);
        tpulse_raw = 1'b1; repeat (FILT_LEN + 1) @(negedge clk); tpulse_raw = 1'b0;
        repeat (40) @(negedge clk);
        chk(width_err_o == 1'b1, "R6", width_err_o, 1);
        err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
        chk(width_err_o == 1'b0, "R6", width_err_o, 0);
        // R10: watchdog timing
        wd_kick = 1'b1; @(negedge clk); wd_kick = 1'b0;
        for (int k = 1; k <= (1 << WD_W); k++) begin
            @(negedge clk);
            chk(wd_reset_o == (k == (1 << WD_W)), "R10", wd_reset_o, k == (1 << WD_W));
        end
        // R10: repeated kicks keep it quiet
        for (int r = 0; r < 3; r++) begin
            wd_kick = 1'b1; @(negedge clk); wd_kick = 1'b0;
            for (int k = 1; k < (1 << WD_W) - 2; k++) begin
                @(negedge clk);
                chk(wd_reset_o == 1'b0, "R10", wd_reset_o, 0);
            end
        end
        mon_en = 0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog timeout actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule